// File: doc/BRIEF.md
# Two-Word Burst Double-Data-Rate SRAM Core

This block is an on-chip static memory with a double-data-rate, separate-input/separate-output interface. Once per interface cycle it samples a load strobe, a read/write select and a word address. Every accepted access moves a pair of words. The second word's address is the loaded address with its least significant bit flipped.

The interface clock pair is modelled as one fast clock `clk`, which runs at twice the interface rate, together with a phase flag `kph`. A `clk` edge with `kph` high stands for the rising edge of the primary input clock. A `clk` edge with `kph` low stands for the rising edge of its complement. The output clock pair is modelled the same way with the flag `cph`. A mode pin `c_hi` says that both output clocks are parked high. In that mode the read data follows the input-clock phases instead of the output-clock phases.

Write words are captured on the two half-cycles that follow the load. Read words come out on a half-cycle-staggered schedule. The output side carries a per-word valid pulse and an output-enable flag. The output-enable flag stands in for the tristate control of a data pad.

Top module: `ddr2b_sram`

## Requirements
- R1: Control inputs (`ld_n`, `rw`, `addr`) are sampled only on `clk` edges with `kph`=1. A load presented at an edge with `kph`=0 does not start a read and does not change the stored contents.
- R2: At a `kph`=1 edge, `ld_n`=0 with `rw`=0 is a write, and `ld_n`=0 with `rw`=1 is a read. `ld_n`=1 is no operation, whatever the value of `rw`: it produces no `dout_vld` pulse and leaves the stored contents unchanged.
- R3: A burst touches the loaded address `A` first and then address `A ^ 1`. So an even address is followed by the odd address above it, and an odd address by the even address below it.
- R4: For a write loaded at `kph`=1 edge number `E`, `din` is stored to `A` at edge `E+2` (the next input-clock rising edge) and to `A ^ 1` at edge `E+3` (the complement edge right after it).
- R5: With `c_hi`=1, a read loaded at edge `E` drives word `A` on `dout` after edge `E+3` and word `A ^ 1` after edge `E+4`. `dout_vld` is 1 for exactly those two edges.
- R6: With `c_hi`=0, the output phase is taken from `cph` (1 = output clock, 0 = its complement). Word `A` is driven at the first edge at or after `E+2` at which `cph`=0, and word `A ^ 1` is driven at the next edge. `cph` alternates every edge.
- R7: After reset `dout_oe`=0, `dout_vld`=0 and `dout`=0. `dout_oe` becomes 1 with the first driven read word and then stays at 1.
- R8: On edges with no read word, `dout` holds the last word that was driven.
- R9: Commands are accepted on every input-clock cycle back to back. A read loaded in the cycle right after a write to the same address returns the newly written words. A read loaded before a write returns the older contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two edges per interface cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| kph | input | 1 | 1 = this edge is the input-clock rising edge, 0 = its complement |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Burst start word address |
| din | input | DW | Write data, one word per edge |
| c_hi | input | 1 | 1 = output clocks parked high, output follows `kph` |
| cph | input | 1 | Output-clock phase, 1 = output clock edge, 0 = its complement |
| dout | output | DW | Read data |
| dout_vld | output | 1 | 1 on edges that drive a read word |
| dout_oe | output | 1 | Output enable; 0 stands for a high-impedance bus |

## Verification
Every address is written and read back in a sweep. The starting addresses cover both even and odd values, so both burst orders appear, and a wrong order shows up as swapped words. Loads placed on complement-phase edges and no-operation cycles with either `rw` value are followed by full read-backs. This separates ignored commands from executed ones. Write-then-read and read-then-write pairs to the same address, issued on adjacent cycles, tell commit order from read sampling time. The read sweeps run with the input-clock fallback, with the output clocks aligned and with the output clocks shifted by half a cycle. Each driven word is checked on the exact edge it is expected, so a slip of one phase in either direction is caught.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_WR  = 2'd1,
        CMD_RD  = 2'd2
    } cmd_e;
endpackage

// File: rtl/ddr2b_array.sv
module ddr2b_array #(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Storage is never reset: contents survive reset and idle clocks.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read before write: a read in the same edge as a write sees the old word.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ddr2b_wrpath.sv
module ddr2b_wrpath
    import ddr2b_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kph,
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr,
    output logic          we,
    output logic [AW-1:0] waddr
);
    localparam logic [AW-1:0] FLIP = AW'(1);

    typedef struct packed {
        logic          w0_v;
        logic [AW-1:0] w0_a;
        logic          w1_v;
        logic [AW-1:0] w1_a;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        waddr = '0;
        st_d.w1_v = 1'b0;
        // First word: next input-clock edge after the load.
        if (kph && st_q.w0_v) begin
            we        = 1'b1;
            waddr     = st_q.w0_a;
            st_d.w1_v = 1'b1;
            st_d.w1_a = st_q.w0_a ^ FLIP;
            st_d.w0_v = 1'b0;
        end
        // Second word: the complement edge right after.
        if (st_q.w1_v) begin
            we    = 1'b1;
            waddr = st_q.w1_a;
        end
        if (cmd == CMD_WR) begin
            st_d.w0_v = 1'b1;
            st_d.w0_a = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_second_word_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.w1_v |-> !kph);
    assert_burst_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kph && st_q.w0_v) |=> (st_q.w1_v && (waddr == ($past(st_q.w0_a) ^ FLIP))));
endmodule

// File: rtl/ddr2b_rdseq.sv
module ddr2b_rdseq
    import ddr2b_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kph,
    input  logic          c_hi,
    input  logic          cph,
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] raddr,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          dout_oe
);
    localparam logic [AW-1:0] FLIP = AW'(1);

    typedef struct packed {
        logic          s0_v;
        logic [AW-1:0] s0_a;
        logic          s1_v;
        logic [AW-1:0] s1_a;
        logic          s2_v;
        logic [AW-1:0] s2_a;
        logic [DW-1:0] dq;
        logic          vld;
        logic          oe;
    } rst_t;

    rst_t st_d, st_q;
    logic eph;
    logic emit;

    // Output phase: input clocks when the output clocks are parked high.
    assign eph = c_hi ? kph : cph;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.s2_v = 1'b0;
        emit      = 1'b0;
        raddr     = '0;
        if (st_q.s2_v) begin
            emit  = 1'b1;
            raddr = st_q.s2_a;
        end
        if (st_q.s1_v && !eph) begin
            emit      = 1'b1;
            raddr     = st_q.s1_a;
            st_d.s2_v = 1'b1;
            st_d.s2_a = st_q.s1_a ^ FLIP;
            st_d.s1_v = 1'b0;
        end
        if (st_q.s0_v) begin
            st_d.s1_v = 1'b1;
            st_d.s1_a = st_q.s0_a;
            st_d.s0_v = 1'b0;
        end
        if (cmd == CMD_RD) begin
            st_d.s0_v = 1'b1;
            st_d.s0_a = addr;
        end
        if (emit) begin
            st_d.dq  = rdata;
            st_d.vld = 1'b1;
            st_d.oe  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout     = st_q.dq;
    assign dout_vld = st_q.vld;
    assign dout_oe  = st_q.oe;

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s0_v && st_q.s1_v) |-> !eph);
    assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.s2_v && st_q.s1_v && !eph));
    assert_word2_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2_v |=> (dout_vld && dout_oe));
    assert_oe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |=> dout_oe);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> $stable(dout));
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kph,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          c_hi,
    input  logic          cph,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          dout_oe
);
    cmd_e          cmd;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;

    // Command decode: only input-clock edges carry commands.
    always_comb begin
        cmd = CMD_NOP;
        if (kph && !ld_n) begin
            cmd = rw ? CMD_RD : CMD_WR;
        end
    end

    ddr2b_wrpath #(.AW(AW)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .kph   (kph),
        .cmd   (cmd),
        .addr  (addr),
        .we    (we),
        .waddr (waddr)
    );

    ddr2b_rdseq #(.AW(AW), .DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kph      (kph),
        .c_hi     (c_hi),
        .cph      (cph),
        .cmd      (cmd),
        .addr     (addr),
        .raddr    (raddr),
        .rdata    (rdata),
        .dout     (dout),
        .dout_vld (dout_vld),
        .dout_oe  (dout_oe)
    );

    ddr2b_array #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n || !kph) |-> !(u_rd.st_d.s0_v && !u_rd.st_q.s0_v && !$past(1'b0)));
endmodule

// File: tb/ddr2b_sram_tb.sv
module ddr2b_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DW    = 18;
    localparam int DEPTH = 1 << AW;
    localparam int MAXE  = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kph = 1'b0;
    logic          ld_n = 1'b1;
    logic          rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          c_hi = 1'b1;
    logic          cph = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_vld;
    logic          dout_oe;

    ddr2b_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .kph(kph), .ld_n(ld_n), .rw(rw),
        .addr(addr), .din(din), .c_hi(c_hi), .cph(cph),
        .dout(dout), .dout_vld(dout_vld), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int n = 0;
    bit mode_hi = 1;
    bit mode_shift = 0;
    string phase_tag = "R2";

    logic [DW-1:0] refm [DEPTH];
    logic [DW-1:0] sdin [MAXE];
    logic [DW-1:0] exd  [MAXE];
    bit            exv  [MAXE];
    int            exk  [MAXE];
    logic [DW-1:0] last_d = '0;
    bit            exp_oe = 0;

    function automatic bit eph_at(int e);
        if (mode_hi || !mode_shift) return (e % 2 == 0);
        return (e % 2 == 1);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_prev();
        int e;
        if (n == 0) return;
        e = n - 1;
        chk(dout_vld === exv[e], mode_hi ? "R5" : "R6",
            $sformatf("dout_vld edge %0d (%s)", e, phase_tag), DW'(dout_vld), DW'(exv[e]));
        if (exv[e]) begin
            chk(dout === exd[e], (exk[e] == 2) ? "R3" : "R4",
                $sformatf("dout word%0d edge %0d (%s)", exk[e], e, phase_tag), dout, exd[e]);
            last_d = exd[e];
            exp_oe = 1;
        end else begin
            chk(dout === last_d, "R8", $sformatf("dout hold edge %0d", e), dout, last_d);
        end
        chk(dout_oe === exp_oe, "R7", $sformatf("dout_oe edge %0d", e), DW'(dout_oe), DW'(exp_oe));
    endtask

    task automatic edge_go(input bit l, input bit r, input logic [AW-1:0] a);
        logic [DW-1:0] w1, w2;
        int fe;
        @(negedge clk);
        check_prev();
        c_hi = mode_hi;
        kph  = (n % 2 == 0);
        cph  = mode_shift ? ~kph : kph;
        ld_n = l;
        rw   = r;
        addr = a;
        din  = sdin[n];
        if (kph && !l) begin
            if (!r) begin
                w1 = DW'(n * 29 + int'(a) * 3 + 5);
                w2 = DW'(n * 53 + 11) ^ DW'(18'h2AAAA);
                sdin[n+2] = w1;
                sdin[n+3] = w2;
                refm[a] = w1;
                refm[a ^ AW'(1)] = w2;
            end else begin
                fe = (eph_at(n + 2) == 1'b0) ? n + 2 : n + 3;
                exv[fe] = 1; exd[fe] = refm[a]; exk[fe] = 1;
                exv[fe+1] = 1; exd[fe+1] = refm[a ^ AW'(1)]; exk[fe+1] = 2;
            end
        end
        @(posedge clk);
        n++;
    endtask

    task automatic kcyc(input bit l, input bit r, input logic [AW-1:0] a);
        edge_go(l, r, a);
        edge_go(1'b1, 1'b0, '0);
    endtask

    task automatic idle(input int k);
        repeat (k) kcyc(1'b1, 1'b0, '0);
    endtask

    task automatic read_all();
        for (int a = 0; a < DEPTH; a++) kcyc(1'b0, 1'b1, AW'(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAXE; i++) sdin[i] = DW'(i * 7 + 100003);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        chk(dout_oe === 1'b0, "R7", "dout_oe after reset", DW'(dout_oe), '0);
        chk(dout_vld === 1'b0, "R7", "dout_vld after reset", DW'(dout_vld), '0);
        chk(dout === '0, "R7", "dout after reset", dout, '0);

        // R4 and R2: back-to-back writes over all addresses, then read back (R3, R5)
        phase_tag = "R4";
        for (int a = 0; a < DEPTH; a++) kcyc(1'b0, 1'b0, AW'(a));
        idle(2);
        read_all();
        idle(3);

        // R2: no-operation with either rw value, output must hold (R8)
        phase_tag = "R2";
        kcyc(1'b1, 1'b1, AW'(3));
        kcyc(1'b1, 1'b0, AW'(5));
        kcyc(1'b1, 1'b1, AW'(6));
        idle(2);
        read_all();
        idle(3);

        // R1: loads on complement-phase edges are ignored
        phase_tag = "R1";
        for (int a = 0; a < DEPTH; a++) begin
            edge_go(1'b1, 1'b0, '0);
            edge_go(1'b0, 1'b0, AW'(a));
            edge_go(1'b1, 1'b1, '0);
            edge_go(1'b0, 1'b1, AW'(a));
        end
        idle(3);
        read_all();
        idle(3);

        // R9: write then read same address, and read then write
        phase_tag = "R9";
        for (int a = 0; a < DEPTH; a += 3) begin
            kcyc(1'b0, 1'b0, AW'(a));
            kcyc(1'b0, 1'b1, AW'(a));
            kcyc(1'b0, 1'b1, AW'(a) ^ AW'(1));
            kcyc(1'b0, 1'b1, AW'(a + 1));
            kcyc(1'b0, 1'b0, AW'(a + 1));
            kcyc(1'b0, 1'b1, AW'(a + 1));
        end
        idle(3);

        // R6: output clocks aligned, then shifted by half a cycle
        phase_tag = "R6";
        mode_hi = 0; mode_shift = 0;
        read_all();
        idle(3);
        mode_shift = 1;
        read_all();
        for (int a = 0; a < DEPTH; a += 2) begin
            kcyc(1'b0, 1'b0, AW'(a + 1));
            kcyc(1'b0, 1'b1, AW'(a + 1));
        end
        idle(3);
        // R5: parked output clocks fall back to input phases, cph ignored
        phase_tag = "R5";
        mode_hi = 1;
        read_all();
        idle(3);

        // Mixed sweep across all modes
        phase_tag = "R9";
        for (int blk = 0; blk < 4; blk++) begin
            mode_hi = (blk == 0);
            mode_shift = (blk % 2 == 1);
            for (int i = 0; i < 50; i++) begin
                int x;
                int k;
                k = blk * 50 + i;
                x = (k * 37 + 11) % 7;
                if (x < 2) kcyc(1'b1, k[0], AW'(k));
                else if (x < 4) kcyc(1'b0, 1'b0, AW'((k * 5 + 3) % DEPTH));
                else kcyc(1'b0, 1'b1, AW'((k * 11 + 1) % DEPTH));
            end
            idle(3);
        end

        @(negedge clk);
        check_prev();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule